// File: doc/BRIEF.md
# Virtual-8086 Mode Entry/Exit Controller

This block holds the processor's virtual-8086 (VM) mode flag and decides, event by event, whether that flag may change. Three kinds of event can arrive. The first is a task switch, which carries the new flags image and says whether the incoming task state segment is the 32-bit or the 16-bit kind. The second is an interrupt return, which carries the flags image taken from the stack together with the current privilege level (CPL). The third is an interrupt or exception, which carries the handler's privilege level, whether its code segment is conforming, and its code-segment selector.

From these the block updates the VM bit and an address-formation select. That select tells the segment unit to build bases in real-mode style (selector shifted left by four) or through descriptors. When an interrupt leaves virtual-8086 mode normally, the block raises a one-cycle strobe asking the core to push the current flags, which still have VM set. When an interrupt from virtual-8086 mode targets an illegal handler, it raises a general-protection fault and gives the target selector as the error code. Instruction decoding and the stack accesses themselves belong to the surrounding core.

Top module: `v86_mode_ctrl`

## Requirements
- R1: A task switch to a 32-bit task state segment (`ts_wide`=1) loads VM from bit 17 of `ts_flags`. No other bit of the image has any effect.
- R2: A task switch to a 16-bit task state segment (`ts_wide`=0) clears VM whatever `ts_flags` holds.
- R3: Outside virtual-8086 mode, an interrupt return loads VM from bit 17 of `iret_flags` only when `cpl` is 0. With any other `cpl`, VM is left unchanged.
- R4: While VM is 1 the effective privilege level is 3. An interrupt return therefore leaves VM at 1 even when the `cpl` input reads 0.
- R5: An interrupt taken with VM=1 whose handler has privilege 0 and a non-conforming segment pulses `push_flags_o` for one cycle. VM is cleared on that same edge, so the flags pushed still have VM set.
- R6: An interrupt taken with VM=1 whose handler is conforming, or has a privilege other than 0, pulses `gp_fault_o` for one cycle with `gp_code_o` equal to `int_sel`. VM stays 1 and no flags push is requested.
- R7: An interrupt taken with VM=0 changes nothing: VM stays 0 and neither strobe fires.
- R8: When several events arrive in the same cycle, the interrupt is handled first, the interrupt return second and the task switch last. Only the winning event is acted on, and the others are dropped.
- R9: `addr_mode_o` equals VM at all times and changes on the same edge as VM. 1 selects real-style base formation and 0 selects descriptor-based formation.
- R10: Synchronous active-low reset sets every output to 0. All outputs are registered and change on the edge that samples the event. In a cycle with no event, VM holds and both strobes are 0 (with `gp_code_o` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_valid | input | 1 | Task-switch event this cycle |
| ts_wide | input | 1 | 1 = incoming task state segment is the 32-bit kind |
| ts_flags | input | FLAGS_W | Flags image of the incoming task |
| iret_valid | input | 1 | Interrupt-return event this cycle |
| iret_flags | input | FLAGS_W | Flags image taken from the stack |
| cpl | input | 2 | Current privilege level reported by the core |
| int_valid | input | 1 | Interrupt or exception event this cycle |
| int_dpl | input | 2 | Privilege level of the handler's code segment |
| int_conforming | input | 1 | Handler's code segment is conforming |
| int_sel | input | SEL_W | Handler's code-segment selector |
| vm_o | output | 1 | Current VM mode flag |
| addr_mode_o | output | 1 | Base formation select, 1 = real-style |
| push_flags_o | output | 1 | One-cycle request to push the current flags |
| gp_fault_o | output | 1 | One-cycle general-protection fault |
| gp_code_o | output | SEL_W | Fault error code, valid with `gp_fault_o` |

## Verification
The bench targets the paths where the privilege or segment-type gate must block a change. One such path is an interrupt return with `cpl`=0 issued from inside virtual-8086 mode: a design that trusts the `cpl` input there would leave the mode. Another is an interrupt return at `cpl`=2: a design that skips the check would enter the mode. A third is a switch to a 16-bit task segment whose image has bit 17 set: a design that reads the bit anyway would end up in virtual-8086 mode.

The bench also tries conforming and privilege-3 handlers from virtual-8086 mode. A design that got this wrong would push flags and drop VM instead of faulting with the selector. Same-cycle event pairs are driven so that each pairing leaves a different VM value, which exposes any swapped priority. Every step compares `addr_mode_o` against VM, so a select that lags by one cycle is caught.

// File: rtl/v86_pkg.sv
// Shared types for the virtual-8086 mode controller.
// Assumes nothing beyond standard two-state encodings.
package v86_pkg;

    // Which event the arbiter accepted this cycle.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_INT  = 2'd1,
        EV_IRET = 2'd2,
        EV_TS   = 2'd3
    } ev_e;

    // Base formation select driven to the segment unit.
    typedef enum logic {
        AM_DESC = 1'b0,
        AM_REAL = 1'b1
    } am_e;

    localparam logic [1:0] PL_KERNEL = 2'd0;
    localparam logic [1:0] PL_USER   = 2'd3;

endpackage

// File: rtl/v86_evt_arb.sv
// Fixed-priority event arbiter: interrupt, then interrupt return, then task switch.
// Assumes the event valids are single-cycle qualifiers from the core.
module v86_evt_arb
    import v86_pkg::*;
(
    input  logic ts_valid,
    input  logic iret_valid,
    input  logic int_valid,
    output ev_e  grant
);

    // Pick the single highest-priority event present.
    always_comb begin
        if (int_valid)       grant = EV_INT;
        else if (iret_valid) grant = EV_IRET;
        else if (ts_valid)   grant = EV_TS;
        else                 grant = EV_NONE;
    end

endmodule

// File: rtl/v86_next_mode.sv
// Next-state decision for the VM flag and the two strobes.
// Assumes the current VM flag is the registered value; in VM mode CPL is taken as 3.
module v86_next_mode
    import v86_pkg::*;
#(
    parameter int FLAGS_W = 32,
    parameter int VM_POS  = 17,
    parameter int SEL_W   = 16
) (
    input  ev_e                grant,
    input  logic               vm_q,
    input  logic               ts_wide,
    input  logic [FLAGS_W-1:0] ts_flags,
    input  logic [FLAGS_W-1:0] iret_flags,
    input  logic [1:0]         cpl,
    input  logic [1:0]         int_dpl,
    input  logic               int_conforming,
    input  logic [SEL_W-1:0]   int_sel,
    output logic               vm_d,
    output logic               push_d,
    output logic               gp_d,
    output logic [SEL_W-1:0]   code_d
);

    logic [1:0] eff_cpl;
    logic       legal_handler;

    // Virtual-8086 code always runs at the user level.
    assign eff_cpl       = vm_q ? PL_USER : cpl;
    // Only a kernel-level, non-conforming handler may be entered from VM mode.
    assign legal_handler = (int_dpl == PL_KERNEL) && !int_conforming;

    // Resolve the accepted event into new VM value, strobes and error code.
    always_comb begin
        vm_d   = vm_q;
        push_d = 1'b0;
        gp_d   = 1'b0;
        code_d = '0;
        unique case (grant)
            EV_INT: begin
                if (vm_q) begin
                    if (legal_handler) begin
                        push_d = 1'b1;
                        vm_d   = 1'b0;
                    end else begin
                        gp_d   = 1'b1;
                        code_d = int_sel;
                    end
                end
            end
            EV_IRET: begin
                if (eff_cpl == PL_KERNEL) vm_d = iret_flags[VM_POS];
            end
            EV_TS: begin
                vm_d = ts_wide ? ts_flags[VM_POS] : 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/v86_mode_reg.sv
// State and output registers of the controller.
// Assumes synchronous active-low reset; address mode is kept in its own flop.
module v86_mode_reg
    import v86_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vm_d,
    input  logic             push_d,
    input  logic             gp_d,
    input  logic [SEL_W-1:0] code_d,
    output logic             vm_q,
    output am_e              am_q,
    output logic             push_q,
    output logic             gp_q,
    output logic [SEL_W-1:0] code_q
);

    // Register the mode flag together with its address-formation select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vm_q <= 1'b0;
            am_q <= AM_DESC;
        end else begin
            vm_q <= vm_d;
            am_q <= vm_d ? AM_REAL : AM_DESC;
        end
    end

    // Register the one-cycle strobes and the fault code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 1'b0;
            gp_q   <= 1'b0;
            code_q <= '0;
        end else begin
            push_q <= push_d;
            gp_q   <= gp_d;
            code_q <= code_d;
        end
    end

endmodule

// File: rtl/v86_mode_ctrl.sv
// Top of the virtual-8086 mode entry/exit controller.
// Assumes at most one event of each kind per cycle; outputs are registered.
module v86_mode_ctrl
    import v86_pkg::*;
#(
    parameter int FLAGS_W = 32,
    parameter int VM_POS  = 17,
    parameter int SEL_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ts_valid,
    input  logic               ts_wide,
    input  logic [FLAGS_W-1:0] ts_flags,
    input  logic               iret_valid,
    input  logic [FLAGS_W-1:0] iret_flags,
    input  logic [1:0]         cpl,
    input  logic               int_valid,
    input  logic [1:0]         int_dpl,
    input  logic               int_conforming,
    input  logic [SEL_W-1:0]   int_sel,
    output logic               vm_o,
    output logic               addr_mode_o,
    output logic               push_flags_o,
    output logic               gp_fault_o,
    output logic [SEL_W-1:0]   gp_code_o
);

    localparam bit POS_OK = (VM_POS >= 0) && (VM_POS < FLAGS_W);

    ev_e              grant;
    logic             vm_q;
    logic             vm_d;
    logic             push_d;
    logic             gp_d;
    logic [SEL_W-1:0] code_d;
    am_e              am_q;

    // Reject a flag position outside the image at elaboration.
    generate
        if (!POS_OK) begin : g_bad_pos
            initial $error("VM_POS outside flags image");
        end
    endgenerate

    v86_evt_arb u_arb (
        .ts_valid   (ts_valid),
        .iret_valid (iret_valid),
        .int_valid  (int_valid),
        .grant      (grant)
    );

    v86_next_mode #(
        .FLAGS_W (FLAGS_W),
        .VM_POS  (VM_POS),
        .SEL_W   (SEL_W)
    ) u_next (
        .grant          (grant),
        .vm_q           (vm_q),
        .ts_wide        (ts_wide),
        .ts_flags       (ts_flags),
        .iret_flags     (iret_flags),
        .cpl            (cpl),
        .int_dpl        (int_dpl),
        .int_conforming (int_conforming),
        .int_sel        (int_sel),
        .vm_d           (vm_d),
        .push_d         (push_d),
        .gp_d           (gp_d),
        .code_d         (code_d)
    );

    v86_mode_reg #(
        .SEL_W (SEL_W)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .vm_d   (vm_d),
        .push_d (push_d),
        .gp_d   (gp_d),
        .code_d (code_d),
        .vm_q   (vm_q),
        .am_q   (am_q),
        .push_q (push_flags_o),
        .gp_q   (gp_fault_o),
        .code_q (gp_code_o)
    );

    assign vm_o        = vm_q;
    assign addr_mode_o = am_q;

endmodule

// File: rtl/v86_mode_chk.sv
// Checker for the virtual-8086 mode controller, bound to every instance.
// Assumes the same parameters as the top; observes ports only.
module v86_mode_chk #(
    parameter int FLAGS_W = 32,
    parameter int VM_POS  = 17,
    parameter int SEL_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ts_valid,
    input logic               ts_wide,
    input logic [FLAGS_W-1:0] ts_flags,
    input logic               iret_valid,
    input logic [FLAGS_W-1:0] iret_flags,
    input logic [1:0]         cpl,
    input logic               int_valid,
    input logic [1:0]         int_dpl,
    input logic               int_conforming,
    input logic [SEL_W-1:0]   int_sel,
    input logic               vm_o,
    input logic               addr_mode_o,
    input logic               push_flags_o,
    input logic               gp_fault_o,
    input logic [SEL_W-1:0]   gp_code_o
);

    logic ts_only;
    logic iret_only;
    logic idle;

    assign ts_only   = ts_valid && !iret_valid && !int_valid;
    assign iret_only = iret_valid && !int_valid;
    assign idle      = !ts_valid && !iret_valid && !int_valid;

    AST_TS_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ts_only && ts_wide |=> vm_o == $past(ts_flags[VM_POS])); // R1
    AST_TS_NARROW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ts_only && !ts_wide |=> !vm_o); // R2
    AST_IRET_KERNEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        iret_only && !vm_o && cpl == 2'd0 |=> vm_o == $past(iret_flags[VM_POS])); // R3
    AST_IRET_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        iret_only && !vm_o && cpl != 2'd0 |=> !vm_o); // R3
    AST_IRET_IN_V86_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        iret_only && vm_o |=> vm_o); // R4
    AST_INT_EXIT_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid && vm_o && int_dpl == 2'd0 && !int_conforming
        |=> push_flags_o && !vm_o && !gp_fault_o); // R5
    AST_INT_BAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid && vm_o && (int_dpl != 2'd0 || int_conforming)
        |=> gp_fault_o && vm_o && !push_flags_o && gp_code_o == $past(int_sel)); // R6
    AST_INT_NATIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid && !vm_o |=> !vm_o && !push_flags_o && !gp_fault_o); // R7
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_flags_o && gp_fault_o)); // R8
    AST_ADDR_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode_o == vm_o); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(vm_o) && !push_flags_o && !gp_fault_o && gp_code_o == '0); // R10

endmodule

bind v86_mode_ctrl v86_mode_chk #(
    .FLAGS_W (FLAGS_W),
    .VM_POS  (VM_POS),
    .SEL_W   (SEL_W)
) u_chk (.*);

// File: tb/sim_v86_mode_ctrl.sv
// Directed bench for the virtual-8086 mode controller.
module sim_v86_mode_ctrl;

    localparam int FW = 32;
    localparam int SW = 16;
    localparam logic [FW-1:0] VM_SET = 32'h0002_0000;
    localparam logic [FW-1:0] VM_CLR = 32'hFFFD_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ts_valid = 1'b0;
    logic          ts_wide = 1'b0;
    logic [FW-1:0] ts_flags = '0;
    logic          iret_valid = 1'b0;
    logic [FW-1:0] iret_flags = '0;
    logic [1:0]    cpl = 2'd0;
    logic          int_valid = 1'b0;
    logic [1:0]    int_dpl = 2'd0;
    logic          int_conforming = 1'b0;
    logic [SW-1:0] int_sel = '0;
    logic          vm_o;
    logic          addr_mode_o;
    logic          push_flags_o;
    logic          gp_fault_o;
    logic [SW-1:0] gp_code_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    v86_mode_ctrl u0 (.*);

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Check all outputs after one applied event; addr mode must follow VM (R9).
    task automatic expect_out(input string req, input logic vm, input logic push,
                              input logic gp, input logic [SW-1:0] code);
        chk({req, " vm"}, 32'(vm_o), 32'(vm));
        chk("R9 addr_mode", 32'(addr_mode_o), 32'(vm));
        chk({req, " push"}, 32'(push_flags_o), 32'(push));
        chk({req, " gp"}, 32'(gp_fault_o), 32'(gp));
        chk({req, " code"}, 32'(gp_code_o), 32'(code));
    endtask

    // Hold the staged inputs over one edge, then clear them and settle.
    task automatic apply();
        @(negedge clk);
        ts_valid = 1'b0; iret_valid = 1'b0; int_valid = 1'b0;
    endtask

    task automatic set_ts(input logic wide, input logic [FW-1:0] f);
        ts_valid = 1'b1; ts_wide = wide; ts_flags = f;
    endtask

    task automatic set_iret(input logic [1:0] c, input logic [FW-1:0] f);
        iret_valid = 1'b1; cpl = c; iret_flags = f;
    endtask

    task automatic set_int(input logic [1:0] d, input logic conf, input logic [SW-1:0] s);
        int_valid = 1'b1; int_dpl = d; int_conforming = conf; int_sel = s;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R10 reset", 1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R10 idle", 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_task_switch();
        set_ts(1'b1, VM_SET); apply();
        expect_out("R1 wide set", 1'b1, 1'b0, 1'b0, '0);
        set_ts(1'b1, VM_CLR); apply();
        expect_out("R1 wide clr", 1'b0, 1'b0, 1'b0, '0);
        set_ts(1'b1, VM_SET); apply();
        set_ts(1'b0, 32'hFFFF_FFFF); apply();
        expect_out("R2 narrow", 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_iret();
        set_iret(2'd2, VM_SET); apply();
        expect_out("R3 cpl2 hold", 1'b0, 1'b0, 1'b0, '0);
        set_iret(2'd0, VM_SET); apply();
        expect_out("R3 cpl0 load", 1'b1, 1'b0, 1'b0, '0);
        set_iret(2'd0, VM_CLR); apply();
        expect_out("R4 v86 hold", 1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic t_interrupt();
        set_int(2'd3, 1'b0, 16'h1234); apply();
        expect_out("R6 dpl3", 1'b1, 1'b0, 1'b1, 16'h1234);
        set_int(2'd0, 1'b1, 16'hABC8); apply();
        expect_out("R6 conforming", 1'b1, 1'b0, 1'b1, 16'hABC8);
        @(negedge clk);
        expect_out("R10 strobe drop", 1'b1, 1'b0, 1'b0, '0);
        set_int(2'd0, 1'b0, 16'h0040); apply();
        expect_out("R5 exit", 1'b0, 1'b1, 1'b0, '0);
        @(negedge clk);
        expect_out("R10 push drop", 1'b0, 1'b0, 1'b0, '0);
        set_int(2'd3, 1'b1, 16'h5555); apply();
        expect_out("R7 native", 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_priority();
        set_iret(2'd0, VM_SET); set_ts(1'b0, '0); apply();
        expect_out("R8 iret over ts", 1'b1, 1'b0, 1'b0, '0);
        set_iret(2'd0, VM_CLR); set_ts(1'b1, VM_CLR); apply();
        expect_out("R8 ts dropped", 1'b1, 1'b0, 1'b0, '0);
        set_int(2'd0, 1'b0, 16'h0008); set_ts(1'b1, VM_SET); apply();
        expect_out("R8 int over ts", 1'b0, 1'b1, 1'b0, '0);
        set_int(2'd0, 1'b0, 16'h0008); set_iret(2'd0, VM_SET); apply();
        expect_out("R8 int over iret", 1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_task_switch();
        t_iret();
        t_interrupt();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule